// File: doc/BRIEF.md
# Indirect Controller Register Bridge

This block lets a host reach a small bank of 8-bit controller registers through a single 64-bit command register. The host writes one command word. The word carries a go flag, a read/write flag, an opcode and a register selector. The block holds the go flag set while the access is in progress. It then performs the access on the addressed register and clears the flag. A polling host therefore reads back the same register until the flag drops, and for a read it takes the result from the low byte.

The bank holds the following registers:

- a data byte;
- a control byte;
- a clock-control byte;
- a status byte, which the bus engine beside the bridge loads and the host can only read.

One selector value triggers a soft reset of the bank. Commands that arrive while an access is still in flight are dropped, and each drop is recorded in a sticky flag.

Top module: `csr_indirect_bridge`

## Requirements
- R1: After reset, every bit of `csr_rdata` is 0. `data_q`, `ctl_q` and `clkctl_q` are 0, and a status read returns 0xF8.
- R2: A command word with go bit 63 set and opcode bits 60:57 equal to 6 raises `csr_rdata[63]` for exactly `LAT` cycles and then clears it.
- R3: A write (bit 56 clear) with selector bits 34:32 equal to 1 stores bits 7:0 into `data_q`. With selector 2 it stores bits 7:0 into `ctl_q`.
- R4: Selector 3 decodes differently by direction. A write to it updates `clkctl_q`, and a read from it returns the status byte.
- R5: When a read completes, bits 7:0 of `csr_rdata` hold the addressed register. Bit 56 and the selector bits read back exactly as they were written.
- R6: A command written while bit 63 is still set is ignored and leaves the in-flight access unchanged. It also sets `csr_rdata[62]`, which stays set until reset.
- R7: A write to selector 7 does the following:
  - clears `data_q` and `ctl_q`;
  - sets the status byte to 0xF8;
  - leaves `clkctl_q` unchanged;
  - pulses `soft_rst` for one cycle.
- R8: A command whose opcode is not 6 never shows bit 63 set. It returns 0 in bits 7:0 and changes no register.
- R9: When an access completes, the block gives one one-cycle pulse on `wr_stb` (for a write) or `rd_stb` (for a read). The pulse occurs in the first cycle that bit 63 reads 0, and `acc_sel` then holds the selector.
- R10: A pulse on `stat_ld` loads `stat_in` into the status byte. A status read returns that byte.
- R11: Selectors 0, 4, 5 and 6 change no register, and a read from any of them returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Host write strobe for the command register |
| csr_wdata | input | 64 | Command word |
| csr_rdata | output | 64 | Command register readback: bit 63 busy, bit 62 overrun, bits 7:0 result |
| stat_ld | input | 1 | Bus engine loads the status byte |
| stat_in | input | 8 | Status byte from the bus engine |
| data_q | output | 8 | Data register |
| ctl_q | output | 8 | Control register |
| clkctl_q | output | 8 | Clock-control register |
| wr_stb | output | 1 | One-cycle pulse when a write completes |
| rd_stb | output | 1 | One-cycle pulse when a read completes |
| acc_sel | output | 3 | Selector of the last completed access |
| soft_rst | output | 1 | One-cycle pulse on a soft-reset write |

## Verification
A stuck or miscounted latency counter shows up as bit 63 staying set for more or fewer than `LAT` cycles. This is visible within a few cycles of the first command. A wrong selector decode surfaces at the completion of the next access: the wrong register output changes, or the wrong byte returns in bits 7:0. Selector 3 in particular would return the clock-control byte instead of status. A busy flag that drops too early lets a second command overwrite the first, which shows in the readback and in a missing overrun bit one access later.

// File: rtl/csr_indirect_bridge.sv
module csr_indirect_bridge #(
  parameter int LAT = 3,
  parameter logic [7:0] IDLE_STAT = 8'hF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  input  logic        stat_ld,
  input  logic [7:0]  stat_in,
  output logic [7:0]  data_q,
  output logic [7:0]  ctl_q,
  output logic [7:0]  clkctl_q,
  output logic        wr_stb,
  output logic        rd_stb,
  output logic [2:0]  acc_sel,
  output logic        soft_rst
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [63:0] cmd_q;
  logic        busy, ovr;
  logic [CW-1:0] cnt;
  logic [7:0]  stat_q, rd_byte;

  wire        accept = csr_wr && !busy;
  wire        is_ext = csr_wdata[60:57] == 4'd6;
  wire [2:0]  sel    = cmd_q[34:32];
  wire        is_rd  = cmd_q[56];

  assign csr_rdata = {busy, ovr, cmd_q[61:0]};

  always_comb begin
    case (sel)
      3'd1:    rd_byte = data_q;
      3'd2:    rd_byte = ctl_q;
      3'd3:    rd_byte = stat_q;
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      busy     <= 1'b0;
      ovr      <= 1'b0;
      cnt      <= '0;
      stat_q   <= IDLE_STAT;
      data_q   <= '0;
      ctl_q    <= '0;
      clkctl_q <= '0;
      wr_stb   <= 1'b0;
      rd_stb   <= 1'b0;
      acc_sel  <= '0;
      soft_rst <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      rd_stb   <= 1'b0;
      soft_rst <= 1'b0;
      if (stat_ld) stat_q <= stat_in;
      if (csr_wr && busy) ovr <= 1'b1;
      if (accept) begin
        cmd_q <= is_ext ? csr_wdata : {csr_wdata[63:8], 8'h00};
        busy  <= is_ext;
        cnt   <= CW'(LAT - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy    <= 1'b0;
          acc_sel <= sel;
          if (is_rd) begin
            cmd_q[7:0] <= rd_byte;
            rd_stb     <= 1'b1;
          end else begin
            wr_stb <= 1'b1;
            case (sel)
              3'd1: data_q   <= cmd_q[7:0];
              3'd2: ctl_q    <= cmd_q[7:0];
              3'd3: clkctl_q <= cmd_q[7:0];
              3'd7: begin
                data_q   <= '0;
                ctl_q    <= '0;
                stat_q   <= IDLE_STAT;
                soft_rst <= 1'b1;
              end
              default: ;
            endcase
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csr_indirect_bridge_chk.sv
module csr_indirect_bridge_chk #(
  parameter int LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] csr_rdata,
  input logic [7:0]  data_q,
  input logic [7:0]  ctl_q,
  input logic        wr_stb,
  input logic        rd_stb,
  input logic        soft_rst
);
  int vcnt;
  wire valid = csr_rdata[63];

  always_ff @(posedge clk) begin
    if (!rst_n) vcnt <= 0;
    else        vcnt <= valid ? vcnt + 1 : 0;
  end

  assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> vcnt < LAT);
  assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> vcnt == LAT);
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[62] |=> csr_rdata[62]);
  assert_strobe_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb) |-> (!valid && $past(valid)));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));
  assert_soft_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (data_q == 8'h00 && ctl_q == 8'h00 && wr_stb));
endmodule

bind csr_indirect_bridge csr_indirect_bridge_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_rdata(csr_rdata), .data_q(data_q),
  .ctl_q(ctl_q), .wr_stb(wr_stb), .rd_stb(rd_stb), .soft_rst(soft_rst)
);

// File: tb/csr_indirect_bridge_bench.sv
module csr_indirect_bridge_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        stat_ld = 1'b0;
  logic [7:0]  stat_in = '0;
  logic [7:0]  data_q, ctl_q, clkctl_q;
  logic        wr_stb, rd_stb, soft_rst;
  logic [2:0]  acc_sel;

  int total = 0, bad = 0;
  int busy_n;
  logic wseen, rseen, sseen;

  csr_indirect_bridge #(.LAT(LAT)) u_csr_indirect_bridge (.*);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] op, input logic rd, input logic [2:0] sel, input logic [7:0] b);
    return (64'd1 << 63) | (64'(op) << 57) | (64'(rd) << 56) | (64'(sel) << 32) | 64'(b);
  endfunction

  task automatic issue(input logic [63:0] w);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = w;
    @(negedge clk);
    csr_wr = 1'b0;
    busy_n = 0;
    while (csr_rdata[63] && busy_n < 50) begin
      busy_n++;
      @(negedge clk);
    end
    wseen = wr_stb; rseen = rd_stb; sseen = soft_rst;
  endtask

  task automatic t_reset;
    chk(csr_rdata == 64'd0, "R1 rdata", csr_rdata, 0);
    chk(data_q == 0 && ctl_q == 0 && clkctl_q == 0, "R1 regs", {data_q, ctl_q, clkctl_q}, 0);
    issue(mk(4'd6, 1'b1, 3'd3, 8'h00));
    chk(csr_rdata[7:0] == 8'hF8, "R1 status", csr_rdata[7:0], 8'hF8);
  endtask

  task automatic t_write_data_ctl;
    issue(mk(4'd6, 1'b0, 3'd1, 8'hA5));
    chk(busy_n == LAT, "R2 busy cycles", busy_n, LAT);
    chk(data_q == 8'hA5, "R3 data write", data_q, 8'hA5);
    chk(wseen && !rseen && acc_sel == 3'd1, "R9 write strobe", {wseen, rseen, acc_sel}, {1'b1, 1'b0, 3'd1});
    @(negedge clk);
    chk(!wr_stb, "R9 strobe one cycle", wr_stb, 0);
    issue(mk(4'd6, 1'b0, 3'd2, 8'h3C));
    chk(ctl_q == 8'h3C && data_q == 8'hA5, "R3 ctl write", {data_q, ctl_q}, 16'hA53C);
  endtask

  task automatic t_read_back;
    logic [63:0] w;
    w = mk(4'd6, 1'b1, 3'd1, 8'h00);
    issue(w);
    chk(csr_rdata[7:0] == 8'hA5, "R5 read data", csr_rdata[7:0], 8'hA5);
    chk(csr_rdata[56] && csr_rdata[34:32] == 3'd1 && !csr_rdata[63], "R5 fields", csr_rdata, w);
    chk(rseen && !wseen && acc_sel == 3'd1, "R9 read strobe", {wseen, rseen, acc_sel}, {1'b0, 1'b1, 3'd1});
    issue(mk(4'd6, 1'b1, 3'd2, 8'h00));
    chk(csr_rdata[7:0] == 8'h3C, "R5 read ctl", csr_rdata[7:0], 8'h3C);
  endtask

  task automatic t_sel3;
    issue(mk(4'd6, 1'b0, 3'd3, 8'h5E));
    chk(clkctl_q == 8'h5E, "R4 clkctl write", clkctl_q, 8'h5E);
    issue(mk(4'd6, 1'b1, 3'd3, 8'h00));
    chk(csr_rdata[7:0] == 8'hF8, "R4 sel3 read is status", csr_rdata[7:0], 8'hF8);
  endtask

  task automatic t_stat_load;
    @(negedge clk);
    stat_ld = 1'b1; stat_in = 8'h28;
    @(negedge clk);
    stat_ld = 1'b0;
    issue(mk(4'd6, 1'b1, 3'd3, 8'h00));
    chk(csr_rdata[7:0] == 8'h28, "R10 status load", csr_rdata[7:0], 8'h28);
  endtask

  task automatic t_soft_reset;
    issue(mk(4'd6, 1'b0, 3'd7, 8'hFF));
    chk(sseen, "R7 soft_rst pulse", sseen, 1);
    chk(data_q == 0 && ctl_q == 0, "R7 data/ctl cleared", {data_q, ctl_q}, 0);
    chk(clkctl_q == 8'h5E, "R7 clkctl kept", clkctl_q, 8'h5E);
    @(negedge clk);
    chk(!soft_rst, "R7 pulse one cycle", soft_rst, 0);
    issue(mk(4'd6, 1'b1, 3'd3, 8'h00));
    chk(csr_rdata[7:0] == 8'hF8, "R7 status idle", csr_rdata[7:0], 8'hF8);
  endtask

  task automatic t_unused_sel;
    issue(mk(4'd6, 1'b0, 3'd1, 8'h77));
    issue(mk(4'd6, 1'b0, 3'd2, 8'h66));
    for (int s = 4; s <= 6; s++) begin
      issue(mk(4'd6, 1'b0, 3'(s), 8'h11));
      issue(mk(4'd6, 1'b1, 3'(s), 8'h00));
      chk(csr_rdata[7:0] == 8'h00, "R11 unused read", csr_rdata[7:0], 0);
    end
    issue(mk(4'd6, 1'b0, 3'd0, 8'h22));
    chk(data_q == 8'h77 && ctl_q == 8'h66 && clkctl_q == 8'h5E, "R11 no effect",
        {data_q, ctl_q, clkctl_q}, 24'h77665E);
  endtask

  task automatic t_non_ext;
    issue(mk(4'd1, 1'b0, 3'd1, 8'h99));
    chk(busy_n == 0, "R8 no busy", busy_n, 0);
    chk(csr_rdata[7:0] == 8'h00 && data_q == 8'h77, "R8 no effect", {csr_rdata[7:0], data_q}, 16'h0077);
    issue(mk(4'd0, 1'b1, 3'd2, 8'h00));
    chk(busy_n == 0 && csr_rdata[7:0] == 8'h00, "R8 read zero", csr_rdata[7:0], 0);
  endtask

  task automatic t_overrun;
    chk(!csr_rdata[62], "R6 no overrun yet", csr_rdata[62], 0);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = mk(4'd6, 1'b0, 3'd1, 8'h42);
    @(negedge clk);
    csr_wdata = mk(4'd6, 1'b0, 3'd2, 8'hEE);
    @(negedge clk);
    csr_wr = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk(data_q == 8'h42 && ctl_q == 8'h66, "R6 second ignored", {data_q, ctl_q}, 16'h4266);
    chk(csr_rdata[62] && csr_rdata[7:0] == 8'h42 && csr_rdata[34:32] == 3'd1, "R6 overrun flag",
        csr_rdata, 64'h0);
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00));
    chk(csr_rdata[62], "R6 overrun sticky", csr_rdata[62], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_data_ctl();
    t_read_back();
    t_sel3();
    t_stat_load();
    t_soft_reset();
    t_unused_sel();
    t_non_ext();
    t_overrun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule